// File: doc/BRIEF.md
# Filtered quadrature position counter

This block turns the two phase signals of an incremental encoder into a position count. The phase pins may change at any time relative to the clock. Each pin is captured by a sampling flip-flop and then passed through a digital noise filter. The filter accepts a new level only after that level has been seen on three filter samples in a row. The filter samples once every 1, 2, 4 or 8 clocks, as chosen by a divide select input.

The filtered phase pair is decoded in 4x mode, so every edge of either phase counts as one step. The count runs up or down through the range zero to a programmable maximum and wraps at both ends. A wrap in either direction raises a sticky flag, which stays set until an explicit clear strobe removes it. A direction output reports whether the most recent valid step was forward or reverse.

Because of the filter, a full quadrature period must last at least 16 clocks at the 1:1 divide ratio, and proportionally longer at the slower ratios.

Top module: `qdec_poscount`

## Requirements
- R1: While reset is asserted, and after it is released, the count reads 0, the flag reads 0 and the direction reads 1 (forward).
- R2: At divide ratio 1:1, a single-phase pin change is first visible on the count after the fourth rising clock edge following the edge that first samples the new pin level.
- R3: At divide ratio 1:1, a pin pulse that lasts 2 clocks or less produces no count change.
- R4: The filter samples once every 2^div_sel clocks. At that ratio, a pulse lasting at most 2·2^div_sel clocks is rejected, and a level held for 4·2^div_sel clocks or more is counted.
- R5: The phase pair is {A,B}, with A in bit 1. Forward follows the sequence 00→01→11→10→00; the reverse transitions count down. Every single-phase edge changes the count by exactly one.
- R6: On a forward step with count equal to max_cnt, the count becomes 0 and the flag is set.
- R7: On a reverse step with count 0, the count becomes max_cnt and the flag is set.
- R8: The flag stays at 1 until flag_clr is sampled high. After that it reads 0 on the following cycle if no new wrap occurs.
- R9: When flag_clr and a wrap fall in the same clock, the flag ends up set.
- R10: A filtered transition in which both phases change at once is ignored: the count and the direction keep their values.
- R11: The direction output is 1 after a forward step and 0 after a reverse step, and it holds that value until the next valid step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pha_i | input | 1 | Raw phase A pin, asynchronous |
| phb_i | input | 1 | Raw phase B pin, asynchronous |
| max_cnt | input | CW | Highest count value before wrapping |
| div_sel | input | SELW | Filter clock divide select; the ratio is 2^div_sel |
| flag_clr | input | 1 | Clears the wrap flag |
| pos_o | output | CW | Position count |
| dir_o | output | 1 | 1 = last step was forward, 0 = reverse |
| flag_o | output | 1 | Sticky wrap flag |

## Verification
The hardest case to reach from the pins is a wrap that lands in the same clock as a flag clear. The wrap happens at the end of a multi-stage filter pipeline, so it cannot be seen at the pins when it happens. The bench first proves the exact latency at the 1:1 ratio. It then times the clear strobe to the fourth clock edge after the sampling edge, so the clear coincides with the underflow. Random walks with a small maximum and changing divide ratios then cross both wrap points many times. Short glitches and simultaneous two-phase changes are also mixed in.

// File: rtl/qdec_poscount.sv
module qdec_poscount #(
  parameter int CW   = 16,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pha_i,
  input  logic            phb_i,
  input  logic [CW-1:0]   max_cnt,
  input  logic [SELW-1:0] div_sel,
  input  logic            flag_clr,
  output logic [CW-1:0]   pos_o,
  output logic            dir_o,
  output logic            flag_o
);
  localparam int PW = (1 << SELW) - 1;

  logic [PW-1:0] pcnt;
  logic [1:0]    samp, h0, h1, filt, filt_d;
  logic [CW-1:0] pos_q;
  logic          dir_q, flag_q;

  wire [PW-1:0] mask   = ~({PW{1'b1}} << div_sel);
  wire          tick   = &(pcnt | ~mask);
  wire [1:0]    agree  = ~(samp ^ h0) & ~(h0 ^ h1);
  wire [1:0]    chg    = filt ^ filt_d;
  wire          single = ^chg;
  wire          up     = filt_d[1] ^ filt[0];
  wire          wrap_up = single & up & (pos_q == max_cnt);
  wire          wrap_dn = single & ~up & (pos_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      samp <= '0;
      h0 <= '0;
      h1 <= '0;
      filt <= '0;
      filt_d <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
      samp <= {pha_i, phb_i};
      filt_d <= filt;
      if (tick) begin
        h0 <= samp;
        h1 <= h0;
        filt <= (filt & ~agree) | (samp & agree);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      dir_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (single) begin
        dir_q <= up;
        if (wrap_up)      pos_q <= '0;
        else if (wrap_dn) pos_q <= max_cnt;
        else if (up)      pos_q <= pos_q + 1'b1;
        else              pos_q <= pos_q - 1'b1;
      end
      flag_q <= (flag_q & ~flag_clr) | wrap_up | wrap_dn;
    end
  end

  assign pos_o  = pos_q;
  assign dir_o  = dir_q;
  assign flag_o = flag_q;

  assert_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    single |=> (pos_q == $past(pos_q) + 1'b1) || (pos_q == $past(pos_q) - 1'b1) ||
               (pos_q == '0) || (pos_q == $past(max_cnt)));

  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (single && pos_q <= max_cnt) |=> pos_q <= $past(max_cnt));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && (pos_q == '0) && single && !up) |=> flag_q);

  assert_double_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chg == 2'b11) |=> ($stable(pos_q) && $stable(dir_q)));
endmodule

// File: tb/qdec_poscount_tb.sv
`timescale 1ns/1ps
module qdec_poscount_tb_top;
  localparam int CW = 16;
  logic clk = 1'b0, rst_n = 1'b0, pha = 1'b0, phb = 1'b0, clr = 1'b0;
  logic [CW-1:0] maxc = 16'd9;
  logic [1:0] sel = 2'd0;
  logic [CW-1:0] pos;
  logic dir, flag;
  int checks = 0, fails = 0;
  int exp_pos = 0, exp_dir = 1, exp_flag = 0;
  logic [1:0] cur = 2'b00;

  always #10 clk = ~clk;

  qdec_poscount #(.CW(CW), .SELW(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pha_i(pha), .phb_i(phb), .max_cnt(maxc),
    .div_sel(sel), .flag_clr(clr), .pos_o(pos), .dir_o(dir), .flag_o(flag));

  function automatic int dirof(logic [1:0] p, logic [1:0] c);
    case ({p, c})
      4'b0001, 4'b0111, 4'b1110, 4'b1000: return 1;
      4'b0100, 4'b1101, 4'b1011, 4'b0010: return -1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(logic [1:0] nw);
    int d = dirof(cur, nw);
    if (d == 1) begin
      exp_dir = 1;
      if (exp_pos == int'(maxc)) begin exp_pos = 0; exp_flag = 1; end
      else exp_pos++;
    end else if (d == -1) begin
      exp_dir = 0;
      if (exp_pos == 0) begin exp_pos = int'(maxc); exp_flag = 1; end
      else exp_pos--;
    end
    cur = nw;
  endtask

  task automatic drive(logic [1:0] nw, int hold);
    @(negedge clk);
    {pha, phb} = nw;
    model(nw);
    repeat (hold) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    chk({tag, " count"}, int'(pos), exp_pos);
    chk({tag, " dir R11"}, int'(dir), exp_dir);
    chk({tag, " flag"}, int'(flag), exp_flag);
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    exp_flag = 0;
    chk("R8 clear", int'(flag), 0);
  endtask

  function automatic logic [1:0] fwd(logic [1:0] c);
    return {c[0], ~c[1]};
  endfunction
  function automatic logic [1:0] rev(logic [1:0] c);
    return {~c[0], c[1]};
  endfunction

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 after reset");

    // R2: latency at 1:1
    @(negedge clk); {pha, phb} = 2'b01; model(2'b01);
    repeat (4) @(negedge clk);
    chk("R2 before 4th edge", int'(pos), 0);
    @(negedge clk);
    chk("R2 at 4th edge", int'(pos), 1);
    repeat (5) @(negedge clk);

    // R3: 2-clock glitch on A
    @(negedge clk); pha = 1'b1;
    repeat (2) @(negedge clk); pha = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 glitch rejected", int'(pos), exp_pos);

    // R10: both phases change together, 01 -> 10
    @(negedge clk); {pha, phb} = 2'b10; cur = 2'b10;
    repeat (10) @(negedge clk);
    chk("R10 count kept", int'(pos), exp_pos);
    chk("R10 dir kept", int'(dir), exp_dir);

    drive(2'b11, 10); check_all("R5 reverse step");
    drive(2'b01, 10); check_all("R7 underflow");
    repeat (20) @(negedge clk);
    chk("R8 sticky", int'(flag), 1);
    clear_flag();
    drive(2'b11, 10); check_all("R6 overflow");
    clear_flag();

    // R9: clear in same clock as underflow (11 -> 01 from count 0)
    @(negedge clk); {pha, phb} = 2'b01; model(2'b01);
    repeat (4) @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R9 set wins", int'(flag), 1);
    chk("R9 count", int'(pos), exp_pos);
    clear_flag();

    // R4: ratio 4, pulse of 8 clocks rejected, held step counted
    sel = 2'd2;
    repeat (20) @(negedge clk);
    @(negedge clk); pha = 1'b1;
    repeat (8) @(negedge clk); pha = 1'b0;
    repeat (40) @(negedge clk);
    chk("R4 long glitch rejected", int'(pos), exp_pos);
    drive(fwd(cur), 26); check_all("R4 slow step");

    begin
      int r;
      void'($urandom(32'h5eed));
      for (int i = 0; i < 300; i++) begin
        if (i % 50 == 0) sel = 2'($urandom_range(0, 3));
        r = 4 * (1 << sel) + 10;
        if ($urandom_range(0, 3) == 0) drive(rev(cur), r);
        else if ($urandom_range(0, 2) == 0) drive(rev(cur), r);
        else drive(fwd(cur), r);
        check_all("R5 random");
        if ($urandom_range(0, 9) == 0) clear_flag();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule